// File: doc/BRIEF.md
# Processor Idle-State Clock Stop Controller

This block moves a single processor between three idle levels: running (C0), auto-halt (C1) and the stop-clock level (C2). Software enters C2 by reading the level-2 idle register, shown to the block as a one-cycle `lvl2_rd` strobe. The block then pulls the active-low `stpclk_n` output low to halt the processor's instruction stream, waits for the processor's stop-grant bus cycle, and watches a set of wake sources. When one of them fires, it releases `stpclk_n` and returns to C0. C1 is entered and left by processor-reported halt and resume pulses. The block records C1 but never stops the clock for it. Requests for deeper levels are dropped.

While the clock is stopped, the processor's active-low floating-point-error pin is reused as a pending-wake indicator. The block captures the pin's value at the moment `stpclk_n` falls. It hands that captured value to the downstream error logic through `ferr_out_n` for the whole stop interval, so the error logic never sees the pin's reused meaning. After `stpclk_n` rises, the captured value is held for `RESTORE_CYC` more cycles, and then `ferr_out_n` follows the live pin again. At 250 MHz the default of 4 cycles keeps the handover well inside a 120 ns bound.

Top module: `cstate_ctl`

## Requirements
- R1: A `deep_req` pulse (request for C3/C4) while in C0 with no other request leaves `cstate` at 2'b00 and `stpclk_n` high.
- R2: A `lvl2_rd` pulse in C0 gives `cstate` = 2'b10 (waiting for grant) and `stpclk_n` = 0 on the next cycle. `lvl2_rd` has priority over `halt_ent`. The state codes are C0 = 00, C1 = 01, wait-grant = 10 and stopped = 11.
- R3: `halt_ent` in C0 moves to C1 (01) with `stpclk_n` kept high. In C1, `lvl2_rd` is ignored. `halt_exit` returns the block to C0.
- R4: The value of `ferr_n` in the cycle of the `lvl2_rd` strobe is captured. `ferr_out_n` shows that value for as long as `stpclk_n` is low, whatever `ferr_n` does.
- R5: The stopped state (11) is reached only on a `stpgnt` pulse. A wake event seen while waiting for the grant is kept. On the grant the block then goes to C0 instead of 11.
- R6: In state 11 with `pbe_en` = 1, `ferr_n` = 0 gives C0 with `stpclk_n` high on the next cycle. With `pbe_en` = 0, `ferr_n` is not a wake source.
- R7: In state 11, each of the following gives C0 with `stpclk_n` high one cycle later: any bit set in `irq_req` whose `irq_mask` bit is 0 (1 = masked), `nmi_smi_evt`, or `init_evt`. Masked requests have no effect.
- R8: After `stpclk_n` rises, `ferr_out_n` keeps the captured value for exactly `RESTORE_CYC` cycles and then equals `ferr_n`.
- R9: Reset gives `cstate` = 00, `stpclk_n` = 1 and `ferr_out_n` equal to `ferr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl2_rd | input | 1 | Read strobe of the level-2 idle register |
| deep_req | input | 1 | Read strobe of a deeper idle level (ignored) |
| halt_ent | input | 1 | Processor entered auto-halt |
| halt_exit | input | 1 | Processor left auto-halt |
| stpgnt | input | 1 | Stop-grant cycle observed |
| ferr_n | input | 1 | Error / pending-wake pin, active low |
| pbe_en | input | 1 | Enable for the pin as a wake source |
| irq_req | input | NUM_IRQ | Interrupt requests, including SCI |
| irq_mask | input | NUM_IRQ | Interrupt mask, 1 = masked |
| nmi_smi_evt | input | 1 | Internal event that raises NMI or SMI |
| init_evt | input | 1 | Internal event that asserts INIT |
| stpclk_n | output | 1 | Stop-clock, active low |
| cstate | output | 2 | Current idle-state code |
| ferr_out_n | output | 1 | Error value for downstream logic |

## Verification
The assertions watch these on every cycle: deep requests and C1 never starting a stop, the stopped state being reached only through a grant, the captured error value staying stable while the clock is stopped, and the live pin coming back once the restore window has passed. The timing of each wake source out of the stopped state is also checked continuously, including the pin when enabled and when not. Only the bench's scenarios can show some of this. These are that the captured value really is the pin's level at entry, that a wake event seen before the grant is remembered, that masked interrupts and a disabled pin leave the processor stopped, and the exact cycle at which the output switches back to the pin.

// File: rtl/cstate_ctl.sv
module cstate_ctl #(
  parameter int NUM_IRQ     = 24,
  parameter int RESTORE_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lvl2_rd,
  input  logic               deep_req,
  input  logic               halt_ent,
  input  logic               halt_exit,
  input  logic               stpgnt,
  input  logic               ferr_n,
  input  logic               pbe_en,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_mask,
  input  logic               nmi_smi_evt,
  input  logic               init_evt,
  output logic               stpclk_n,
  output logic [1:0]         cstate,
  output logic               ferr_out_n
);
  localparam int CW = $clog2(RESTORE_CYC + 1);
  localparam logic [1:0] ST_RUN  = 2'b00;
  localparam logic [1:0] ST_HALT = 2'b01;
  localparam logic [1:0] ST_WAIT = 2'b10;
  localparam logic [1:0] ST_STOP = 2'b11;
  localparam logic [CW-1:0] RLOAD = CW'(RESTORE_CYC);

  logic [1:0]    st, st_nx;
  logic          pend, pend_nx;
  logic          ferr_cap;
  logic [CW-1:0] rcnt;
  logic          ext_wake, pin_wake, leave_stop;

  assign ext_wake = (|(irq_req & ~irq_mask)) | nmi_smi_evt | init_evt;
  assign pin_wake = pbe_en & ~ferr_n;

  // deep_req is intentionally not decoded: deeper levels stay in C0
  always_comb begin
    st_nx   = st;
    pend_nx = pend;
    case (st)
      ST_RUN: begin
        pend_nx = 1'b0;
        if (lvl2_rd)       st_nx = ST_WAIT;
        else if (halt_ent) st_nx = ST_HALT;
      end
      ST_HALT: if (halt_exit) st_nx = ST_RUN;
      ST_WAIT: begin
        pend_nx = pend | ext_wake;
        if (stpgnt) st_nx = (pend | ext_wake) ? ST_RUN : ST_STOP;
      end
      default: if (ext_wake | pin_wake) st_nx = ST_RUN;
    endcase
  end

  assign leave_stop = st[1] & (st_nx == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      pend     <= 1'b0;
      ferr_cap <= 1'b1;
      rcnt     <= '0;
    end else begin
      st   <= st_nx;
      pend <= pend_nx;
      if (st == ST_RUN && lvl2_rd) ferr_cap <= ferr_n;
      if (leave_stop)      rcnt <= RLOAD;
      else if (rcnt != 0)  rcnt <= rcnt - 1'b1;
    end
  end

  assign cstate     = st;
  assign stpclk_n   = ~st[1];
  assign ferr_out_n = (st[1] || rcnt != 0) ? ferr_cap : ferr_n;
endmodule

// File: rtl/cstate_ctl_chk.sv
module cstate_ctl_chk #(
  parameter int NUM_IRQ     = 24,
  parameter int RESTORE_CYC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lvl2_rd,
  input logic               deep_req,
  input logic               halt_ent,
  input logic               halt_exit,
  input logic               stpgnt,
  input logic               ferr_n,
  input logic               pbe_en,
  input logic [NUM_IRQ-1:0] irq_req,
  input logic [NUM_IRQ-1:0] irq_mask,
  input logic               nmi_smi_evt,
  input logic               init_evt,
  input logic               stpclk_n,
  input logic [1:0]         cstate,
  input logic               ferr_out_n
);
  localparam int KW = $clog2(RESTORE_CYC + 2);
  localparam logic [KW-1:0] KSAT = KW'(RESTORE_CYC);
  logic [KW-1:0] since_rel;
  logic ext;
  assign ext = (|(irq_req & ~irq_mask)) | nmi_smi_evt | init_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rel <= KSAT;
    else if (!stpclk_n)        since_rel <= '0;
    else if (since_rel < KSAT) since_rel <= since_rel + 1'b1;
  end

  AST_DEEP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cstate == 2'b00 && deep_req && !lvl2_rd && !halt_ent |=> cstate == 2'b00 && stpclk_n); // R1
  AST_L2_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    cstate == 2'b00 && lvl2_rd |=> cstate == 2'b10 && !stpclk_n); // R2
  AST_HALT_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    cstate == 2'b01 && lvl2_rd && !halt_exit |=> cstate == 2'b01 && stpclk_n); // R3
  AST_CAPTURE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stpclk_n && $past(!stpclk_n) |-> $stable(ferr_out_n)); // R4
  AST_GRANT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    cstate == 2'b10 && !stpgnt |=> cstate == 2'b10); // R5
  AST_PIN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    cstate == 2'b11 && pbe_en && !ferr_n |=> cstate == 2'b00 && stpclk_n); // R6
  AST_PIN_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    cstate == 2'b11 && !pbe_en && !ext |=> cstate == 2'b11); // R6
  AST_EXT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    cstate == 2'b11 && ext |=> cstate == 2'b00 && stpclk_n); // R7
  AST_PIN_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    stpclk_n && since_rel >= KSAT |-> ferr_out_n == ferr_n); // R8
endmodule

bind cstate_ctl cstate_ctl_chk #(.NUM_IRQ(NUM_IRQ), .RESTORE_CYC(RESTORE_CYC)) u_chk (.*);

// File: tb/tb_cstate_ctl.sv
module tb_cstate_ctl;
  localparam int NI = 24;
  localparam int RC = 4;
  logic clk = 0, rst_n = 0;
  logic lvl2_rd = 0, deep_req = 0, halt_ent = 0, halt_exit = 0, stpgnt = 0;
  logic ferr_n = 1, pbe_en = 0, nmi_smi_evt = 0, init_evt = 0;
  logic [NI-1:0] irq_req = '0, irq_mask = '0;
  logic stpclk_n, ferr_out_n;
  logic [1:0] cstate;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cstate_ctl #(.NUM_IRQ(NI), .RESTORE_CYC(RC)) dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic enter_c2(input logic pin);
    ferr_n = pin; lvl2_rd = 1; tick(); lvl2_rd = 0;
    chk("R2 wait state", cstate, 2);
    chk("R2 stpclk low", stpclk_n, 0);
    stpgnt = 1; tick(); stpgnt = 0;
    chk("R5 stopped after grant", cstate, 3);
  endtask

  task automatic t_reset;
    chk("R9 reset state", cstate, 0);
    chk("R9 reset stpclk", stpclk_n, 1);
    ferr_n = 0; #1 chk("R9 pin live", ferr_out_n, 0); ferr_n = 1;
  endtask

  task automatic t_deep;
    deep_req = 1; tick(); deep_req = 0;
    chk("R1 deep ignored state", cstate, 0);
    chk("R1 deep ignored stpclk", stpclk_n, 1);
  endtask

  task automatic t_irq_break;
    enter_c2(1);
    irq_mask = 24'h000010; irq_req = 24'h000010; tick();
    chk("R7 masked irq no wake", cstate, 3);
    irq_req = 24'h000100; tick(); irq_req = '0; irq_mask = '0;
    chk("R7 irq wake state", cstate, 0);
    chk("R7 irq wake stpclk", stpclk_n, 1);
    tick(RC);
    enter_c2(1); nmi_smi_evt = 1; tick(); nmi_smi_evt = 0;
    chk("R7 nmi/smi wake", cstate, 0);
    tick(RC);
    enter_c2(1); init_evt = 1; tick(); init_evt = 0;
    chk("R7 init wake", cstate, 0);
    tick(RC);
  endtask

  task automatic t_pending;
    ferr_n = 1; lvl2_rd = 1; tick(); lvl2_rd = 0;
    init_evt = 1; tick(); init_evt = 0;
    chk("R5 wait holds without grant", cstate, 2);
    tick(2);
    stpgnt = 1; tick(); stpgnt = 0;
    chk("R5 pending wake on grant", cstate, 0);
    chk("R5 stpclk released", stpclk_n, 1);
    tick(RC);
  endtask

  task automatic t_pin;
    pbe_en = 0; enter_c2(1);
    ferr_n = 0; tick(3);
    chk("R6 pin ignored when disabled", cstate, 3);
    chk("R4 capture held", ferr_out_n, 1);
    pbe_en = 1; tick();
    chk("R6 pin wake when enabled", cstate, 0);
    chk("R6 stpclk released", stpclk_n, 1);
    pbe_en = 0; ferr_n = 1; tick(RC);
  endtask

  task automatic t_hold;
    enter_c2(0);
    for (int i = 0; i < 4; i++) begin
      ferr_n = ~ferr_n; tick();
      chk("R4 capture holds while pin toggles", ferr_out_n, 0);
    end
    ferr_n = 1; irq_req = 24'h1; tick(); irq_req = '0;
    chk("R8 exit", stpclk_n, 1);
    tick(RC - 1);
    chk("R8 captured until window end", ferr_out_n, 0);
    tick();
    chk("R8 live pin after window", ferr_out_n, 1);
    ferr_n = 0; #1 chk("R8 follows pin", ferr_out_n, 0); ferr_n = 1;
  endtask

  task automatic t_halt;
    halt_ent = 1; tick(); halt_ent = 0;
    chk("R3 halt state", cstate, 1);
    chk("R3 no stop in halt", stpclk_n, 1);
    lvl2_rd = 1; tick(); lvl2_rd = 0;
    chk("R3 lvl2 ignored in halt", cstate, 1);
    halt_exit = 1; tick(); halt_exit = 0;
    chk("R3 halt exit", cstate, 0);
    lvl2_rd = 1; halt_ent = 1; tick(); lvl2_rd = 0; halt_ent = 0;
    chk("R2 lvl2 priority over halt", cstate, 2);
    irq_req = 24'h2; stpgnt = 1; tick(); stpgnt = 0; irq_req = '0;
    tick(RC);
  endtask

  initial begin
    tick(2); #1 rst_n = 1; #0;
    t_reset();
    tick();
    t_deep();
    t_irq_break();
    t_pending();
    t_pin();
    t_hold();
    t_halt();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule